// File: doc/BRIEF.md
# SPI Master Command Shift Engine

This block is one channel of an SPI master that runs a single command-driven burst at a time. A command word sets the direction, the length in bits and whether the chip select stays active once the burst ends. While the burst runs, the engine pulls 32-bit words from a transmit port and shifts them out on MOSI. It packs the bits it samples from MISO into 32-bit words and presents them on a receive port.

Four static inputs set the serial format: clock phase, clock polarity, chip-select level and bit order. Two enable inputs gate the MOSI drive and MISO capture. A further input delays the capture point, for use at the fastest divider. SCLK comes from an integer divider of the system clock. `busy_o` is high for the whole burst and `done_o` pulses once when it ends. Long transfers are built by software as a chain of bursts. Every burst except the last has the continue flag set, so the frame stays open.

Top module: `spi_cmd_engine`

## Requirements
- R1: A command is accepted when `cmd_valid_i` is high, `busy_o` is low and bits 1:0 are nonzero (1 transmit only, 2 receive only, 3 full duplex). Bits 31:16 hold the bit count minus one. `busy_o` rises on the next cycle and stays high for exactly bits × divider cycles. `done_o` then pulses high for one cycle, with `busy_o` low.
- R2: Any command presented while `busy_o` is high has no effect: the running burst keeps its length and only one `done_o` pulse results.
- R3: The SCLK period equals `div_i` system clocks, and values below 4 act as 4. SCLK rests at `cpol_i` when no burst runs. With `cpha_i` low, data is sampled on the first edge of each bit; with `cpha_i` high, on the second edge.
- R4: The chip select is active throughout a burst, and its active level is high when `cs_act_hi_i` is 1 and low otherwise. At the end of the burst it is released unless command bit 4 was set. A mode-0 command given while the engine is not busy releases a held chip select.
- R5: In MSB-first order (`lsb_first_i` = 0), each word carries n = min(32, bits remaining) bits. Bit n-1 goes out first and bit 0 last, so a final short word uses only its low bits.
- R6: In LSB-first order, each word's bit 0 goes out first and bit n-1 last.
- R7: In receive modes with `miso_en_i` high, a word is presented on `rx_data_o` with a one-cycle `rx_valid_o` after its last bit. The word is packed in the same order as transmit and right-aligned. No receive word appears in transmit-only mode or when `miso_en_i` is low.
- R8: In receive-only mode MOSI stays 0 and `tx_ready_o` never rises.
- R9: When a transmitting burst needs a new word and `tx_valid_i` is low, the engine sends zeros for that word and pulses `underflow_o` for one cycle.
- R10: With `alt_cap_i` high, MISO is captured one system clock after the sampling edge instead of at it.
- R11: With `mosi_en_i` low, MOSI stays 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpha_i | input | 1 | Clock phase select |
| cpol_i | input | 1 | SCLK idle level |
| cs_act_hi_i | input | 1 | Chip select active level is high |
| mosi_en_i | input | 1 | Enable MOSI drive |
| miso_en_i | input | 1 | Enable MISO capture |
| lsb_first_i | input | 1 | Bit order, 1 = LSB first |
| alt_cap_i | input | 1 | Delayed MISO capture |
| div_i | input | DIV_W | SCLK divider, minimum 4 |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 16+CNT_W | Command word |
| tx_data_i | input | WORD_W | Transmit word |
| tx_valid_i | input | 1 | Transmit word available |
| tx_ready_o | output | 1 | Transmit word taken this cycle |
| rx_data_o | output | WORD_W | Received word |
| rx_valid_o | output | 1 | Received word strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Burst finished pulse |
| underflow_o | output | 1 | Transmit word missing pulse |

## Verification
The delayed capture mode is the hardest behaviour to observe from the ports. Normal sampling and sampling one system clock later read the same MISO value unless the serial partner changes its data in exactly that one-cycle gap. The bench therefore has a second slave mode that advances MISO one system clock after each sampling edge it observes. In that mode only the delayed capture returns the expected pattern, and the normal capture returns the pattern shifted by one bit. A command injected mid-burst and a transmit port that runs dry part way through a two-word burst cover the ignore and underflow paths.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_TX     = 2'd1,
    MODE_RX     = 2'd2,
    MODE_DUPLEX = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/spi_clk_gen.sv
module spi_clk_gen #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_MIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpha_i,
  input  logic             cpol_i,
  input  logic             alt_cap_i,
  output logic             sclk_o,
  output logic             bit_start_o,
  output logic             sample_o,
  output logic             bit_end_o
);
  logic [DIV_W-1:0] div_eff, half, cap_at, cnt_q;
  logic             raw;

  always_comb begin
    div_eff = (div_i < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_i;
    half    = div_eff >> 1;
    cap_at  = alt_cap_i ? half + DIV_W'(1) : half;
  end

  assign bit_start_o = run_i && (cnt_q == '0);
  assign sample_o    = run_i && (cnt_q == cap_at);
  assign bit_end_o   = run_i && (cnt_q == div_eff - DIV_W'(1));

  // Data changes at count 0, sampling sits at mid-bit in both phases
  assign raw    = run_i && (cpha_i ? (cnt_q < half) : (cnt_q >= half));
  assign sclk_o = raw ^ cpol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || bit_end_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + DIV_W'(1);
  end

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < div_eff));
  assert_idle_cnt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i) |=> (cnt_q == '0));
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NB_W  = $clog2(WORD_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic [NB_W-1:0]   load_bits_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              miso_i,
  input  logic              lsb_i,
  output logic              tx_bit_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [WORD_W-1:0] tx_q, rx_q, rx_nxt;
  logic [NB_W-1:0]   len_q;

  always_comb begin
    rx_nxt = rx_q;
    if (sample_i) rx_nxt = lsb_i ? {miso_i, rx_q[WORD_W-1:1]} : {rx_q[WORD_W-2:0], miso_i};
  end

  assign tx_bit_o  = lsb_i ? tx_q[0] : tx_q[WORD_W-1];
  // LSB-first words fill from the top; right-align them on output
  assign rx_word_o = lsb_i ? (rx_nxt >> (NB_W'(WORD_W) - len_q)) : rx_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      len_q <= '0;
    end else if (load_i) begin
      tx_q  <= lsb_i ? load_word_i : (load_word_i << (NB_W'(WORD_W) - load_bits_i));
      rx_q  <= '0;
      len_q <= load_bits_i;
    end else begin
      if (shift_i) tx_q <= lsb_i ? (tx_q >> 1) : (tx_q << 1);
      rx_q <= rx_nxt;
    end
  end

  assert_len_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_bits_i <= NB_W'(WORD_W)) && (load_bits_i != '0));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned DIV_MIN = 4,
  localparam int unsigned CMD_W  = 16 + CNT_W,
  localparam int unsigned NB_W   = $clog2(WORD_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpha_i,
  input  logic              cpol_i,
  input  logic              cs_act_hi_i,
  input  logic              mosi_en_i,
  input  logic              miso_en_i,
  input  logic              lsb_first_i,
  input  logic              alt_cap_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              underflow_o
);
  localparam int unsigned CONT_BIT = 4;
  localparam int unsigned CNT_LSB  = 16;

  logic              busy_q, cs_on_q, cont_q, done_q, rx_valid_q;
  xfer_mode_e        mode_q, cmd_mode;
  logic [CNT_W:0]    left_q;
  logic [NB_W-1:0]   wrem_q, wlen_new;
  logic [WORD_W-1:0] rx_data_q, rx_word, load_word;
  logic              bit_start, sample, bit_end, word_start;
  logic              do_tx, do_rx, accept, idle_cmd, tx_bit;
  logic              unused_cmd;

  assign unused_cmd = ^{cmd_i[CNT_LSB-1:CONT_BIT+1], cmd_i[CONT_BIT-1:2]};
  assign cmd_mode   = xfer_mode_e'(cmd_i[1:0]);
  assign accept     = cmd_valid_i && !busy_q && (cmd_mode != MODE_IDLE);
  assign idle_cmd   = cmd_valid_i && !busy_q && (cmd_mode == MODE_IDLE);
  assign do_tx      = (mode_q == MODE_TX) || (mode_q == MODE_DUPLEX);
  assign do_rx      = ((mode_q == MODE_RX) || (mode_q == MODE_DUPLEX)) && miso_en_i;
  assign word_start = bit_start && (wrem_q == '0);
  assign wlen_new   = (left_q > (CNT_W+1)'(WORD_W)) ? NB_W'(WORD_W) : left_q[NB_W-1:0];

  assign tx_ready_o  = word_start && do_tx;
  assign underflow_o = tx_ready_o && !tx_valid_i;
  assign load_word   = (tx_ready_o && tx_valid_i) ? tx_data_i : '0;

  assign mosi_o      = busy_q && do_tx && mosi_en_i && tx_bit;
  assign cs_o        = cs_act_hi_i ? cs_on_q : !cs_on_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign rx_valid_o  = rx_valid_q;
  assign rx_data_o   = rx_data_q;

  spi_clk_gen #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_clk (
    .clk_i, .rst_ni, .run_i(busy_q), .div_i, .cpha_i, .cpol_i, .alt_cap_i,
    .sclk_o, .bit_start_o(bit_start), .sample_o(sample), .bit_end_o(bit_end)
  );

  spi_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .load_i(word_start), .load_word_i(load_word), .load_bits_i(wlen_new),
    .shift_i(bit_start && !word_start), .sample_i(sample && do_rx), .miso_i,
    .lsb_i(lsb_first_i), .tx_bit_o(tx_bit), .rx_word_o(rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cs_on_q    <= 1'b0;
      cont_q     <= 1'b0;
      mode_q     <= MODE_IDLE;
      left_q     <= '0;
      wrem_q     <= '0;
      done_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        cs_on_q <= 1'b1;
        cont_q  <= cmd_i[CONT_BIT];
        mode_q  <= cmd_mode;
        left_q  <= {1'b0, cmd_i[CMD_W-1:CNT_LSB]} + (CNT_W+1)'(1);
        wrem_q  <= '0;
      end else if (idle_cmd) begin
        cs_on_q <= 1'b0;
      end
      if (word_start) wrem_q <= wlen_new;
      if (bit_end) begin
        left_q <= left_q - (CNT_W+1)'(1);
        wrem_q <= wrem_q - NB_W'(1);
        if (wrem_q == NB_W'(1) && do_rx) begin
          rx_valid_q <= 1'b1;
          rx_data_q  <= rx_word;
        end
        if (left_q == (CNT_W+1)'(1)) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          cs_on_q <= cont_q;
        end
      end
    end
  end

  assert_done_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_ignore_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i && !bit_end) |=> (left_q == $past(left_q)));
  assert_sclk_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |-> (sclk_o == cpol_i));
  assert_cs_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cs_o == cs_act_hi_i));
  assert_rx_only_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_q == MODE_RX) |-> (!mosi_o && !tx_ready_o));
  assert_uf_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> !underflow_o);
endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cpha = 0, cpol = 0, cs_act_hi = 0, mosi_en = 1, miso_en = 1, lsb = 0, alt = 0;
  logic [15:0] div = 16'd4;
  logic cmd_valid = 0;
  logic [31:0] cmd = '0;
  logic [31:0] tx_data, rx_data;
  logic tx_valid, tx_ready, rx_valid, sclk, mosi, miso, cs, busy, done, uf;

  logic [31:0] tx_mem [0:7];
  int tx_n = 0, tx_ptr = 0;
  logic tx_clr = 0;
  assign tx_valid = (tx_ptr < tx_n);
  assign tx_data  = tx_valid ? tx_mem[tx_ptr] : 32'd0;
  always @(posedge clk) begin
    if (tx_clr) tx_ptr <= 0;
    else if (tx_ready && tx_valid) tx_ptr <= tx_ptr + 1;
  end

  spi_cmd_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cpha_i(cpha), .cpol_i(cpol), .cs_act_hi_i(cs_act_hi),
    .mosi_en_i(mosi_en), .miso_en_i(miso_en), .lsb_first_i(lsb), .alt_cap_i(alt),
    .div_i(div), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_o(cs), .busy_o(busy), .done_o(done),
    .underflow_o(uf)
  );

  // scoreboard storage: driver writes, monitor reads
  logic        exp_mosi [0:2047];
  logic [31:0] exp_rx [0:255];
  int mosi_wr = 0, mosi_rd = 0, rx_wr = 0, rx_rd = 0;
  logic miso_bits [0:255];
  string cur_tag = "R1";
  logic late_mode = 0;
  int exp_div = 4;

  int tb_chk = 0, tb_err = 0, mon_chk = 0, mon_err = 0;
  int cyc = 0, busy_cyc = 0, done_cnt = 0, uf_cnt = 0, rdy_cnt = 0;
  int midx = 0, last_lead = -1;
  logic late_pend = 0, prev_sclk = 0, lead;

  assign miso = (midx >= 0) ? miso_bits[midx] : 1'b0;

  // monitor and slave model
  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cyc++;
    if (done) done_cnt++;
    if (uf) uf_cnt++;
    if (tx_ready) rdy_cnt++;
    if (busy && cs !== cs_act_hi) begin
      mon_chk++; mon_err++;
      $display("FAIL R4 cs during burst: actual %0b expected %0b", cs, cs_act_hi);
    end
    if (rx_valid) begin
      mon_chk++;
      if (rx_rd >= rx_wr) begin
        mon_err++;
        $display("FAIL R7 unexpected rx word: actual %h expected none", rx_data);
      end else if (rx_data !== exp_rx[rx_rd]) begin
        mon_err++;
        $display("FAIL %s rx word %0d: actual %h expected %h", cur_tag, rx_rd, rx_data, exp_rx[rx_rd]);
      end
      rx_rd++;
    end
    if (!busy) begin
      midx = (cpha || late_mode) ? -1 : 0;
      late_pend = 0;
      last_lead = -1;
    end else begin
      if (late_pend) begin midx++; late_pend = 0; end
      if (sclk !== prev_sclk) begin
        lead = (prev_sclk == cpol);
        if (lead) begin
          if (last_lead >= 0) begin
            mon_chk++;
            if (cyc - last_lead != exp_div) begin
              mon_err++;
              $display("FAIL R3 sclk period: actual %0d expected %0d", cyc - last_lead, exp_div);
            end
          end
          last_lead = cyc;
        end
        if (cpha ? !lead : lead) begin
          mon_chk++;
          if (mosi_rd >= mosi_wr || mosi !== exp_mosi[mosi_rd]) begin
            mon_err++;
            $display("FAIL %s mosi bit %0d: actual %0b expected %0b", cur_tag, mosi_rd, mosi,
                     (mosi_rd < mosi_wr) ? exp_mosi[mosi_rd] : 1'bx);
          end
          mosi_rd++;
          if (late_mode) late_pend = 1;
        end else if (!late_mode) begin
          midx++;
        end
      end
    end
    prev_sclk = sclk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tb_chk++;
    if (!ok) begin
      tb_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_burst(input logic [1:0] mode, input bit cont, input int nbits,
                           input int supplied, input bit poke, input string tag);
    int nwords, nw, b0, d0, u0, r0, exp_uf, exp_rdy;
    logic [31:0] val;
    logic bt;
    cur_tag = tag;
    exp_div = (div < 4) ? 4 : int'(div);
    nwords = (nbits + 31) / 32;
    for (int w = 0; w < nwords; w++) begin
      nw = (nbits - 32*w > 32) ? 32 : nbits - 32*w;
      val = '0;
      for (int j = 0; j < nw; j++) begin
        bt = (w < supplied) ? (lsb ? tx_mem[w][j] : tx_mem[w][nw-1-j]) : 1'b0;
        exp_mosi[mosi_wr] = mode[0] && mosi_en && bt;
        mosi_wr++;
        if (lsb) val[j] = miso_bits[32*w+j];
        else     val[nw-1-j] = miso_bits[32*w+j];
      end
      if (mode[1] && miso_en) begin exp_rx[rx_wr] = val; rx_wr++; end
    end
    exp_uf  = (mode[0] && nwords > supplied) ? nwords - supplied : 0;
    exp_rdy = mode[0] ? nwords : 0;
    tx_n = supplied;
    @(negedge clk) tx_clr = 1;
    @(negedge clk) tx_clr = 0;
    b0 = busy_cyc; d0 = done_cnt; u0 = uf_cnt; r0 = rdy_cnt;
    cmd = {16'(nbits - 1), 11'd0, cont, 2'd0, mode};
    cmd_valid = 1;
    @(negedge clk) cmd_valid = 0;
    if (poke) begin
      repeat (6) @(negedge clk);
      cmd = {16'd7, 11'd0, 1'b0, 2'd0, 2'd1};
      cmd_valid = 1;
      @(negedge clk) cmd_valid = 0;
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    check(busy_cyc - b0 == nbits * exp_div, {tag, " R1 busy cycles"}, busy_cyc - b0, nbits * exp_div);
    check(done_cnt - d0 == 1, {tag, " R1 done pulses"}, done_cnt - d0, 1);
    check(uf_cnt - u0 == exp_uf, {tag, " R9 underflow pulses"}, uf_cnt - u0, exp_uf);
    check(rdy_cnt - r0 == exp_rdy, {tag, " R8 tx word requests"}, rdy_cnt - r0, exp_rdy);
    check(cs === (cont ? cs_act_hi : !cs_act_hi), {tag, " R4 cs after burst"}, int'(cs),
          int'(cont ? cs_act_hi : !cs_act_hi));
    check(mosi_rd == mosi_wr, {tag, " mosi bits seen"}, mosi_rd, mosi_wr);
    check(rx_rd == rx_wr, {tag, " R7 rx words seen"}, rx_rd, rx_wr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL R1 watchdog expired: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", tb_chk + mon_chk + 1, tb_err + mon_err + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) miso_bits[i] = ((i * 7 + i / 3) % 5) < 2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !uf && !tx_ready && !rx_valid, "R1 reset outputs idle", int'(busy), 0);
    check(cs === 1'b1, "R4 reset cs inactive", int'(cs), 1);
    check(sclk === 1'b0 && mosi === 1'b0, "R3 reset sclk and mosi", int'(sclk), 0);

    // R5 R7: MSB-first duplex, second word partial
    tx_mem[0] = 32'hA5C3_0F1E; tx_mem[1] = 32'h0000_00B7;
    run_burst(2'd3, 0, 40, 2, 0, "R5");

    // R6: LSB-first, mode 3 clocking, active-high cs
    cpol = 1; cpha = 1; lsb = 1; cs_act_hi = 1; div = 16'd6;
    @(negedge clk);
    tx_mem[0] = 32'h000F_2C91;
    run_burst(2'd3, 0, 20, 1, 0, "R6");
    check(sclk === 1'b1, "R3 sclk idles at cpol=1", int'(sclk), 1);
    cpol = 0; cpha = 0; lsb = 0; cs_act_hi = 0; div = 16'd5;
    @(negedge clk);

    // R7: transmit only yields no rx words
    tx_mem[0] = 32'h0000_9D3A;
    run_burst(2'd1, 0, 16, 1, 0, "R7");

    // R8: receive only
    div = 16'd8;
    run_burst(2'd2, 0, 24, 0, 0, "R8");

    // R9: second word missing
    div = 16'd4;
    tx_mem[0] = 32'hDEAD_BEEF;
    run_burst(2'd1, 0, 64, 1, 0, "R9");

    // R4: continue flag holds cs, idle command releases it
    tx_mem[0] = 32'h0000_005A;
    run_burst(2'd3, 1, 8, 1, 0, "R4");
    repeat (4) @(negedge clk);
    check(cs === 1'b0, "R4 cs held between bursts", int'(cs), 0);
    tx_mem[0] = 32'h0000_C3E1;
    run_burst(2'd3, 0, 16, 1, 0, "R4");
    tx_mem[0] = 32'h0000_0011;
    run_burst(2'd1, 1, 8, 1, 0, "R4");
    cmd = 32'h0000_0000; cmd_valid = 1;
    @(negedge clk) cmd_valid = 0;
    @(negedge clk);
    check(cs === 1'b1 && !busy, "R4 idle command releases cs", int'(cs), 1);

    // R2: command during burst ignored
    tx_mem[0] = 32'h1234_5678; tx_mem[1] = 32'h0000_9ABC;
    run_burst(2'd3, 0, 48, 2, 1, "R2");

    // R3: divider below minimum clamps to 4
    div = 16'd2;
    tx_mem[0] = 32'h0000_0096;
    run_burst(2'd1, 0, 8, 1, 0, "R3");

    // R10: delayed capture against a late-changing slave
    div = 16'd4; alt = 1; late_mode = 1;
    @(negedge clk);
    tx_mem[0] = 32'h0F0F_3355;
    run_burst(2'd3, 0, 32, 1, 0, "R10");
    alt = 0; late_mode = 0;
    @(negedge clk);

    // R11 with R7: drive and capture disabled
    mosi_en = 0; miso_en = 0;
    tx_mem[0] = 32'h0000_FFFF;
    run_burst(2'd3, 0, 16, 1, 0, "R11");

    $display("CHECKS %0d ERRORS %0d", tb_chk + mon_chk, tb_err + mon_err);
    $finish;
  end
endmodule